// File: doc/BRIEF.md
# Configuration Completion Receiver with Poll Budget

This block waits for the completion that answers a single-dword configuration request. Once the request builder has issued a request, it polls a completion channel at a fixed interval. On each poll the channel offers a beat made of a start flag, an end flag and two 32-bit words. When a poll happens the block raises a pop strobe, and the channel then moves on to its next beat. The completion status is captured from the start beat. The verdict is reached on the end beat. If the end beat does not arrive within a fixed number of polls, the request is reported as having no device.

For reads the block returns the byte, halfword or dword that the requester asked for, shifted down from the returned dword. A request that the upstream access filter has already rejected never polls. It is answered at once with a not-found result and all-ones data. The response stays on the outputs until the requester acknowledges it.

Top module: `cpl_rx`

## Requirements
- R1: After reset `rsp_valid` and `cpl_pop` are low.
- R2: While a request is pending, `cpl_pop` is high for one cycle out of every `POLL_CYCLES`. The first pop falls in the cycle right after the request is accepted. There is no pop while idle or while a response is held.
- R3: A popped beat is taken only if the start flag or the end flag is set, or if a start has already been seen in this request. A start beat latches the status from bits 14:12 of `cpl_word1`. Beats after the start that carry neither flag leave the latched status unchanged.
- R4: On an end beat the response is an error if the status is nonzero. When the same beat also carries the start flag, that beat's own status is used. The data on any error is 32'hFFFFFFFF.
- R5: The latched status starts out nonzero for each request, so an end beat with no earlier start beat gives an error.
- R6: If `POLL_LIMIT` pops go by with no end beat, the response is an error with all-ones data, and no further pop occurs.
- R7: A successful read returns data selected by `req_size` from `cpl_word0` of the end beat, using `req_offset`. Size 0 gives (word >> 8*offset) & 8'hFF. Size 1 gives (word >> 8*(offset & 2)) & 16'hFFFF. Sizes 2 and 3 give the whole word.
- R8: A successful write (`req_write`=1) returns data 0 with no error.
- R9: A request with `req_reject` set produces, in the next cycle, a response with `rsp_err`=1 and data 32'hFFFFFFFF, and no pop.
- R10: The response (`rsp_valid`, `rsp_err`, `rsp_data`) holds steady until `rsp_ack`. A `req_start` that arrives while a request or a response is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request has been sent; begin waiting |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_reject | input | 1 | Access filter rejected the request |
| req_size | input | 2 | Read size: 0 byte, 1 halfword, 2/3 dword |
| req_offset | input | 2 | Byte offset within the dword |
| cpl_sop | input | 1 | Start flag of the offered beat |
| cpl_eop | input | 1 | End flag of the offered beat |
| cpl_word0 | input | 32 | First completion word (data) |
| cpl_word1 | input | 32 | Second completion word (status in 14:12) |
| cpl_pop | output | 1 | Poll strobe; channel advances after it |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Not-found / error result |
| rsp_data | output | 32 | Read data, or all ones on error |
| rsp_ack | input | 1 | Requester takes the response |

## Verification
Reads with the same completion word are tried at each byte offset and in every size. This separates the byte-lane shift from the halfword shift, which rounds the offset down to the even lane. Status patterns are chosen so that only bits 14:12 decide the outcome. A nonzero status is also placed on a flagless middle beat, which tells latch-on-start-only apart from latch-on-every-beat. End-without-start, start and end on the same beat, a silent channel and a filtered request each reach the error result by a different route. Counting pops and measuring their spacing separates the poll budget from the interval.

// File: rtl/cpl_rx.sv
module cpl_rx #(
  parameter int POLL_LIMIT  = 500,
  parameter int POLL_CYCLES = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic        req_reject,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_offset,
  input  logic        cpl_sop,
  input  logic        cpl_eop,
  input  logic [31:0] cpl_word0,
  input  logic [31:0] cpl_word1,
  output logic        cpl_pop,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_data,
  input  logic        rsp_ack
);

  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int NW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} state_t;

  state_t      state;
  logic [TW-1:0] tick;
  logic [NW-1:0] npoll;
  logic        sop_seen;
  logic [2:0]  cst;
  logic        is_wr;
  logic [1:0]  size_q, off_q;
  logic        busy, beat, last_poll, end_err;
  logic [2:0]  st_now;

  function automatic logic [31:0] pick(input logic [31:0] d, input logic [1:0] sz,
                                       input logic [1:0] off);
    case (sz)
      2'd0:    pick = (d >> (8 * off)) & 32'h0000_00FF;
      2'd1:    pick = (d >> (8 * {off[1], 1'b0})) & 32'h0000_FFFF;
      default: pick = d;
    endcase
  endfunction

  assign busy      = state != S_IDLE;
  assign cpl_pop   = (state == S_WAIT) && (tick == '0);
  assign rsp_valid = state == S_DONE;
  assign beat      = cpl_pop && (cpl_sop || cpl_eop || sop_seen);
  assign st_now    = cpl_sop ? cpl_word1[14:12] : cst;
  assign end_err   = st_now != 3'd0;
  assign last_poll = npoll == NW'(POLL_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tick     <= '0;
      npoll    <= '0;
      sop_seen <= 1'b0;
      cst      <= 3'd1;
      is_wr    <= 1'b0;
      size_q   <= 2'd0;
      off_q    <= 2'd0;
      rsp_err  <= 1'b0;
      rsp_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_start) begin
          if (req_reject) begin
            state    <= S_DONE;
            rsp_err  <= 1'b1;
            rsp_data <= '1;
          end else begin
            state    <= S_WAIT;
            tick     <= '0;
            npoll    <= '0;
            sop_seen <= 1'b0;
            cst      <= 3'd1;
            is_wr    <= req_write;
            size_q   <= req_size;
            off_q    <= req_offset;
          end
        end
        S_WAIT: begin
          tick <= (tick == TW'(POLL_CYCLES - 1)) ? '0 : tick + 1'b1;
          if (cpl_pop) begin
            npoll <= npoll + 1'b1;
            if (beat && cpl_sop) begin
              sop_seen <= 1'b1;
              cst      <= cpl_word1[14:12];
            end
            if (beat && cpl_eop) begin
              state    <= S_DONE;
              rsp_err  <= end_err;
              rsp_data <= end_err ? '1 : (is_wr ? '0 : pick(cpl_word0, size_q, off_q));
            end else if (last_poll) begin
              state    <= S_DONE;
              rsp_err  <= 1'b1;
              rsp_data <= '1;
            end
          end
        end
        default: if (rsp_ack) state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cpl_rx_chk.sv
module cpl_rx_chk #(
  parameter int POLL_CYCLES = 500
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        req_start,
  input logic        req_reject,
  input logic        cpl_pop,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_data,
  input logic        rsp_ack
);

  // R2
  pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cpl_pop);

  // R2
  pop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (POLL_CYCLES > 1) && cpl_pop |=> !cpl_pop);

  // R4
  err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_err |-> rsp_data == 32'hFFFF_FFFF);

  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_start && req_reject |=> rsp_valid && rsp_err && !cpl_pop);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_err) && $stable(rsp_data));

endmodule

bind cpl_rx cpl_rx_chk #(.POLL_CYCLES(POLL_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_start(req_start),
  .req_reject(req_reject), .cpl_pop(cpl_pop), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_data(rsp_data), .rsp_ack(rsp_ack));

// File: tb/cpl_rx_tb_top.sv
module cpl_rx_tb_top;
  localparam int PL = 6;
  localparam int PC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, req_write = 0, req_reject = 0;
  logic [1:0] req_size = 0, req_offset = 0;
  logic cpl_sop = 0, cpl_eop = 0;
  logic [31:0] cpl_word0 = 0, cpl_word1 = 0;
  logic cpl_pop, rsp_valid, rsp_err, rsp_ack = 0;
  logic [31:0] rsp_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpl_rx #(.POLL_LIMIT(PL), .POLL_CYCLES(PC)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic request(input logic wr, input logic rej, input logic [1:0] sz,
                         input logic [1:0] off);
    req_write = wr; req_reject = rej; req_size = sz; req_offset = off; req_start = 1;
    @(negedge clk);
    req_start = 0; req_reject = 0;
  endtask

  task automatic beat(input logic s, input logic e, input logic [31:0] w0, input logic [31:0] w1);
    cpl_sop = s; cpl_eop = e; cpl_word0 = w0; cpl_word1 = w1;
    for (int i = 0; i < 50 && !cpl_pop; i++) @(negedge clk);
    @(negedge clk);
    cpl_sop = 0; cpl_eop = 0; cpl_word0 = 0; cpl_word1 = 0;
  endtask

  task automatic finish_rsp(input string req, input logic err, input logic [31:0] data);
    for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
    check(req, {31'd0, rsp_valid}, 32'd1);
    check(req, {31'd0, rsp_err}, {31'd0, err});
    check(req, rsp_data, data);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    check("R10", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_read(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] exp);
    request(0, 0, sz, off);
    beat(1, 0, 32'h0, 32'hFFFF_8FFF);
    beat(0, 1, 32'hA1B2_C3D4, 32'h0);
    finish_rsp("R7", 0, exp);
  endtask

  task automatic t_write;
    request(1, 0, 2'd2, 2'd0);
    beat(1, 0, 32'h0, 32'h0);
    beat(0, 1, 32'h1234_5678, 32'h0);
    finish_rsp("R8", 0, 32'h0);
  endtask

  task automatic t_status;
    request(0, 0, 2'd2, 2'd0);
    beat(1, 0, 32'h0, 32'h0000_1000);
    beat(0, 1, 32'h5555_5555, 32'h0);
    finish_rsp("R4", 1, 32'hFFFF_FFFF);
    // R3 flagless beats: before start ignored, after start do not relatch
    request(0, 0, 2'd2, 2'd0);
    beat(0, 0, 32'h0, 32'h0000_7000);
    beat(1, 0, 32'h0, 32'h0);
    beat(0, 0, 32'h0, 32'h0000_7000);
    beat(0, 1, 32'hCAFE_F00D, 32'h0);
    finish_rsp("R3", 0, 32'hCAFE_F00D);
    request(0, 0, 2'd2, 2'd0);
    beat(1, 1, 32'h0BAD_BEEF, 32'h0);
    finish_rsp("R4", 0, 32'h0BAD_BEEF);
    request(0, 0, 2'd2, 2'd0);
    beat(1, 1, 32'h0BAD_BEEF, 32'h0000_2000);
    finish_rsp("R4", 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_no_start;
    request(0, 0, 2'd2, 2'd0);
    beat(0, 1, 32'h1111_2222, 32'h0);
    finish_rsp("R5", 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_timeout;
    int pops = 0, first = -1, second = -1, cyc = 0;
    request(0, 0, 2'd2, 2'd0);
    for (int i = 0; i < 100 && !rsp_valid; i++) begin
      if (cpl_pop) begin
        pops++;
        if (first < 0) first = cyc; else if (second < 0) second = cyc;
      end
      cyc++;
      @(negedge clk);
    end
    check("R2", first, 0);
    check("R2", second - first, PC);
    check("R6", pops, PL);
    repeat (2 * PC) begin
      if (cpl_pop) pops++;
      @(negedge clk);
    end
    check("R6", pops, PL);
    finish_rsp("R6", 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reject;
    request(0, 1, 2'd2, 2'd0);
    check("R9", {31'd0, rsp_valid}, 32'd1);
    check("R9", {31'd0, cpl_pop}, 32'd0);
    finish_rsp("R9", 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold;
    int pops = 0;
    request(0, 0, 2'd2, 2'd0);
    beat(1, 1, 32'h7777_8888, 32'h0);
    @(negedge clk);
    req_start = 1; req_reject = 1;
    cpl_sop = 1; cpl_eop = 1; cpl_word0 = 32'h1; cpl_word1 = 32'h0000_7000;
    repeat (2 * PC + 2) begin
      if (cpl_pop) pops++;
      @(negedge clk);
    end
    req_start = 0; req_reject = 0; cpl_sop = 0; cpl_eop = 0;
    check("R10", pops, 0);
    check("R10", rsp_data, 32'h7777_8888);
    finish_rsp("R10", 0, 32'h7777_8888);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {30'd0, rsp_valid, cpl_pop}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {30'd0, rsp_valid, cpl_pop}, 32'd0);
    t_read(2'd0, 2'd1, 32'h0000_00C3);
    t_read(2'd0, 2'd3, 32'h0000_00A1);
    t_read(2'd1, 2'd2, 32'h0000_A1B2);
    t_read(2'd1, 2'd1, 32'h0000_C3D4);
    t_read(2'd2, 2'd3, 32'hA1B2_C3D4);
    t_write;
    t_status;
    t_no_start;
    t_timeout;
    t_reject;
    t_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule